// File: doc/BRIEF.md
# Indexed Multi-Socket Register Port

This block is the host-side register front end of a card-socket bridge. The host sees only two byte-wide locations. A byte written to the index location picks a socket and a register. A read or write at the data location then reaches the byte that the index picks. The upper two index bits choose one of up to four per-socket banks, which gives a stride of 0x40 per socket. The lower six bits choose the register inside the bank.

Each bank holds general control and window bytes, a read-only view of the card pins, a mode byte and a change-interrupt enable byte. It also holds a change register whose bits latch edges on the synchronized card inputs and clear when that register is read. A strap input sets how many sockets are live. A single interrupt output is high while any enabled change bit is pending on a live socket.

The host access strobes are plain single-cycle controls with no back-pressure. Each strobe completes in the cycle it is presented. Read data is registered and appears one cycle after the read strobe.

Top module: `sock_regport`

## Requirements
- R1: After reset the index byte, the read-data output and the interrupt are all zero, and every bank register reads as zero.
- R2: A write strobe with `host_sel_data`=0 loads the index byte, and a read with `host_sel_data`=0 returns it. Data-port accesses reach the register the index selects. Read data appears on `host_rdata` the cycle after the read strobe and holds until the next read.
- R3: Index bits [7:6] give the socket and bits [5:0] give the register, so socket n's register r sits at r + 0x40·n. Banks are independent. Every register other than 0x01 and 0x04 is plain read/write storage. A 16-bit value is kept with its low byte at index r and its high byte at r+1.
- R4: `cfg_strap` sets the live socket count: 2'b00 gives 2, 2'b01 gives 1, and 2'b10 or 2'b11 gives 4. A socket at or above the count reads as 0x00, ignores writes, latches no events and never drives the interrupt.
- R5: Register 0x01 is read-only and shows the synchronized pin levels {2'b00, ready, write-protect, detect2, detect1, batt2, batt1}. The battery and status-change pins are active low. A card is present only when bits 2 and 3 are both 1.
- R6: Register 0x04 bits are sticky. Bit 3 sets when card presence (detect1 AND detect2) changes, and the other bits set on either edge of their synchronized pins. The write-protect pin raises no event.
- R7: Bit 5 of register 0x03 selects I/O-card mode. In that mode bit 0 of 0x04 latches status-change edges on the batt1 pin, and bits 1 and 2 never set. In memory-card mode bits 0, 1 and 2 latch batt1 (dead), batt2 (warning) and ready edges.
- R8: Reading register 0x04 returns the pending bits and clears them. An event landing in the same cycle as that read is not returned by it but stays set afterwards.
- R9: `irq` is the OR, over live sockets, of (register 0x04 AND register 0x05 bits [3:0]). It follows the latched state in the same cycle.
- R10: Pin edges seen during the first SYNC_STAGES+1 cycles after reset latch no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strap | input | 2 | Live socket count select |
| host_sel_data | input | 1 | 0 selects the index location, 1 selects the data location |
| host_wr | input | 1 | Write strobe, one cycle |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| pin_batt1 | input | MAX_SOCK | Battery-dead / status-change pin per socket, active low |
| pin_batt2 | input | MAX_SOCK | Battery-warning pin per socket, active low |
| pin_det1 | input | MAX_SOCK | First card-detect pin per socket |
| pin_det2 | input | MAX_SOCK | Second card-detect pin per socket |
| pin_wprot | input | MAX_SOCK | Write-protect pin per socket |
| pin_ready | input | MAX_SOCK | Card ready pin per socket |
| irq | output | 1 | Enabled change event pending |

## Verification
A wrong change latch shows at the ports as an `irq` level that differs from the enabled pending bits in the same cycle. On the next read of register 0x04 it also shows as a wrong byte. Wrong index decoding or strap decoding shows on the first data-port read of a socket other than zero, as a byte that belongs to another bank or a non-zero byte from a socket that is not live. A lost same-cycle event shows on the second of two back-to-back change reads.

// File: rtl/sock_regport_pkg.sv
package sock_regport_pkg;

  localparam int REG_W  = 6;
  localparam int SOCK_W = 2;
  localparam int BANK_DEPTH = 1 << REG_W;

  localparam logic [REG_W-1:0] IDX_STATUS = 6'h01;
  localparam logic [REG_W-1:0] IDX_MODE   = 6'h03;
  localparam logic [REG_W-1:0] IDX_CHG    = 6'h04;
  localparam logic [REG_W-1:0] IDX_CHG_EN = 6'h05;
  localparam int MODE_IO_BIT = 5;

  // synchronized card pins, one socket
  typedef struct packed {
    logic ready;
    logic wprot;
    logic det2;
    logic det1;
    logic batt2;
    logic batt1;
  } pins_t;

  // change event bits, bit 3 down to bit 0
  typedef struct packed {
    logic det;
    logic ready;
    logic batt2;
    logic batt1;
  } evt_t;

  function automatic logic [2:0] strap_count(input logic [1:0] strap);
    case (strap)
      2'b00:   strap_count = 3'd2;
      2'b01:   strap_count = 3'd1;
      default: strap_count = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sock_evt_sync.sv
module sock_evt_sync
  import sock_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pins_i,
  output pins_t pins_o,
  output evt_t  evt_o
);
  localparam int NBITS = $bits(pins_t);
  localparam int SETTLE = SYNC_STAGES + 1;
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [SYNC_STAGES-1:0][NBITS-1:0] stg_q;
  logic [NBITS-1:0] prev_q;
  logic [CNT_W-1:0] settle_q;
  logic settled;
  pins_t cur, prv;
  logic [NBITS-1:0] flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_q    <= '0;
      prev_q   <= '0;
      settle_q <= '0;
    end else begin
      stg_q[0] <= pins_i;
      for (int k = 1; k < SYNC_STAGES; k++) stg_q[k] <= stg_q[k-1];
      prev_q <= stg_q[SYNC_STAGES-1];
      if (settle_q != CNT_W'(SETTLE)) settle_q <= settle_q + 1'b1;
    end
  end

  assign settled = (settle_q == CNT_W'(SETTLE));
  assign cur  = stg_q[SYNC_STAGES-1];
  assign prv  = prev_q;
  assign flip = cur ^ prv;
  assign pins_o = cur;

  always_comb begin
    evt_o = '0;
    if (settled) begin
      evt_o.batt1 = flip[0];
      evt_o.batt2 = flip[1];
      evt_o.ready = flip[5];
      evt_o.det   = (cur.det1 & cur.det2) ^ (prv.det1 & prv.det2);
    end
  end

  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q < CNT_W'(SETTLE)) |-> (evt_o == '0)); // R10

endmodule

// File: rtl/sock_bank.sv
module sock_bank
  import sock_regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] reg_idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  pins_t            pins,
  input  evt_t             evt,
  output logic             irq_req
);
  logic [7:0] mem_q [BANK_DEPTH];
  logic [3:0] chg_q;
  logic [3:0] new_evt;
  logic       io_mode;
  logic       chg_read;

  assign io_mode  = mem_q[IDX_MODE][MODE_IO_BIT];
  assign chg_read = rd_en && (reg_idx == IDX_CHG);

  always_comb begin
    new_evt[0] = evt.batt1;
    new_evt[1] = evt.batt2 & ~io_mode;
    new_evt[2] = evt.ready & ~io_mode;
    new_evt[3] = evt.det;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BANK_DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en && reg_idx != IDX_STATUS && reg_idx != IDX_CHG) begin
      mem_q[reg_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        chg_q <= '0;
    else if (!active)  chg_q <= '0;
    else if (chg_read) chg_q <= new_evt;
    else               chg_q <= chg_q | new_evt;
  end

  always_comb begin
    case (reg_idx)
      IDX_STATUS: rdata = {2'b00, pins};
      IDX_CHG:    rdata = {4'b0000, chg_q};
      default:    rdata = mem_q[reg_idx];
    endcase
  end

  assign irq_req = active && |(chg_q & mem_q[IDX_CHG_EN][3:0]);

  AST_CHG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (active && chg_read && new_evt == '0) |=> (chg_q == '0)); // R8
  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !chg_read) |=> ((chg_q & $past(chg_q)) == $past(chg_q))); // R6
  AST_IO_NO_BATT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && io_mode && !chg_read) |=> (chg_q[2:1] == $past(chg_q[2:1]))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> (chg_q == '0)); // R4

endmodule

// File: rtl/sock_regport.sv
module sock_regport
  import sock_regport_pkg::*;
#(
  parameter int MAX_SOCK    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_strap,
  input  logic                host_sel_data,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [7:0]          host_wdata,
  output logic [7:0]          host_rdata,
  input  logic [MAX_SOCK-1:0] pin_batt1,
  input  logic [MAX_SOCK-1:0] pin_batt2,
  input  logic [MAX_SOCK-1:0] pin_det1,
  input  logic [MAX_SOCK-1:0] pin_det2,
  input  logic [MAX_SOCK-1:0] pin_wprot,
  input  logic [MAX_SOCK-1:0] pin_ready,
  output logic                irq
);
  localparam int IDX_W = SOCK_W + REG_W;

  logic [IDX_W-1:0]  index_q;
  logic [7:0]        rdata_q;
  logic [SOCK_W-1:0] sock_sel;
  logic [REG_W-1:0]  reg_sel;
  logic [2:0]        live_cnt;
  logic [MAX_SOCK-1:0] live, req;
  logic [7:0]        bank_rd [MAX_SOCK];
  logic [7:0]        data_rd;

  assign sock_sel = index_q[IDX_W-1:REG_W];
  assign reg_sel  = index_q[REG_W-1:0];
  assign live_cnt = strap_count(cfg_strap);

  for (genvar s = 0; s < MAX_SOCK; s++) begin : g_sock
    pins_t raw, syn;
    evt_t  ev;
    logic  hit;
    assign raw  = '{ready: pin_ready[s], wprot: pin_wprot[s], det2: pin_det2[s],
                    det1: pin_det1[s], batt2: pin_batt2[s], batt1: pin_batt1[s]};
    assign live[s] = (3'(s) < live_cnt);
    assign hit  = host_sel_data && (sock_sel == SOCK_W'(s)) && live[s];

    sock_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pins_i(raw), .pins_o(syn), .evt_o(ev));

    sock_bank bank_i (
      .clk(clk), .rst_n(rst_n), .active(live[s]),
      .wr_en(host_wr && hit), .rd_en(host_rd && hit),
      .reg_idx(reg_sel), .wdata(host_wdata), .rdata(bank_rd[s]),
      .pins(syn), .evt(ev), .irq_req(req[s]));
  end

  always_comb begin
    data_rd = '0;
    for (int s = 0; s < MAX_SOCK; s++)
      if (sock_sel == SOCK_W'(s) && live[s]) data_rd = bank_rd[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= '0;
      rdata_q <= '0;
    end else begin
      if (host_wr && !host_sel_data) index_q <= host_wdata;
      if (host_rd) rdata_q <= host_sel_data ? data_rd : index_q;
    end
  end

  assign host_rdata = rdata_q;
  assign irq = |req;

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && !host_sel_data) |=> $stable(index_q)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata)); // R2
  AST_IRQ_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~live) == '0)); // R4

endmodule

// File: tb/sock_regport_tb_top.sv
module sock_regport_tb_top;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_strap = 2'b10;
  logic host_sel_data = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [NS-1:0] pin_batt1 = '1, pin_batt2 = '1, pin_det1 = '0, pin_det2 = '0;
  logic [NS-1:0] pin_wprot = '0, pin_ready = '0;
  logic irq;

  always #2.5 clk = ~clk;

  sock_regport #(.MAX_SOCK(NS), .SYNC_STAGES(2)) dut_i (.*);

  int n_checks = 0, n_fail = 0;
  logic [7:0] m_mem [NS][64];
  logic [3:0] m_chg [NS];

  function automatic int live_count();
    case (cfg_strap)
      2'b00: return 2;
      2'b01: return 1;
      default: return 4;
    endcase
  endfunction

  function automatic logic [7:0] m_status(int s);
    return {2'b00, pin_ready[s], pin_wprot[s], pin_det2[s], pin_det1[s],
            pin_batt2[s], pin_batt1[s]};
  endfunction

  function automatic logic m_irq();
    logic r = 1'b0;
    for (int s = 0; s < live_count(); s++) r |= |(m_chg[s] & m_mem[s][5][3:0]);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(bit sel, logic [7:0] d);
    @(negedge clk);
    host_sel_data = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(bit sel, output logic [7:0] d);
    @(negedge clk);
    host_sel_data = sel; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic reg_wr(int s, logic [5:0] r, logic [7:0] d);
    bus_wr(1'b0, {2'(s), r});
    bus_wr(1'b1, d);
    if (s < live_count() && r != 6'h01 && r != 6'h04) m_mem[s][r] = d;
  endtask

  task automatic reg_chk(int s, logic [5:0] r, string req);
    logic [7:0] got, exp;
    bus_wr(1'b0, {2'(s), r});
    if (s >= live_count()) exp = 8'h00;
    else if (r == 6'h01) exp = m_status(s);
    else if (r == 6'h04) exp = {4'h0, m_chg[s]};
    else exp = m_mem[s][r];
    bus_rd(1'b1, got);
    if (s < live_count() && r == 6'h04) m_chg[s] = '0;
    check(got == exp, req, got, exp);
  endtask

  // which: 0 batt1, 1 batt2, 2 det1, 3 det2, 4 wprot, 5 ready
  task automatic toggle(int s, int which);
    logic pres0, pres1, io;
    logic [3:0] ev = '0;
    pres0 = pin_det1[s] & pin_det2[s];
    @(negedge clk);
    case (which)
      0: pin_batt1[s] = ~pin_batt1[s];
      1: pin_batt2[s] = ~pin_batt2[s];
      2: pin_det1[s]  = ~pin_det1[s];
      3: pin_det2[s]  = ~pin_det2[s];
      4: pin_wprot[s] = ~pin_wprot[s];
      default: pin_ready[s] = ~pin_ready[s];
    endcase
    pres1 = pin_det1[s] & pin_det2[s];
    io = m_mem[s][3][5];
    ev[0] = (which == 0);
    ev[1] = (which == 1) && !io;
    ev[2] = (which == 5) && !io;
    ev[3] = pres0 ^ pres1;
    if (s < live_count()) m_chg[s] |= ev;
    repeat (4) @(negedge clk);
  endtask

  task automatic irq_chk(string req);
    check(irq == m_irq(), req, irq, m_irq());
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      m_chg[s] = '0;
      for (int r = 0; r < 64; r++) m_mem[s][r] = '0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    model_reset();
    // batt pins high (good) and sock0 ready high across reset: no event latched (R10)
    pin_ready[0] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_rdata == 8'h00, "R1 rdata", host_rdata, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    bus_rd(1'b0, d);
    check(d == 8'h00, "R1 index", d, 0);
    repeat (6) @(negedge clk);
    reg_chk(0, 6'h04, "R10 no event at reset");
    reg_chk(3, 6'h20, "R1 bank zero");

    // R2 index readback
    bus_wr(1'b0, 8'h45);
    bus_rd(1'b0, d);
    check(d == 8'h45, "R2 index readback", d, 8'h45);
    bus_rd(1'b0, d);
    @(negedge clk);
    check(host_rdata == 8'h45, "R2 rdata held", host_rdata, 8'h45);

    // R3 banks and 16-bit pairs
    reg_wr(0, 6'h10, 8'hA5);
    reg_wr(2, 6'h10, 8'h5A);
    reg_wr(1, 6'h20, 8'h34);
    reg_wr(1, 6'h21, 8'h12);
    reg_chk(0, 6'h10, "R3 sock0");
    reg_chk(2, 6'h10, "R3 sock2 stride");
    reg_chk(1, 6'h20, "R3 low byte");
    reg_chk(1, 6'h21, "R3 high byte");

    // R5 status read-only, presence
    reg_wr(0, 6'h01, 8'hFF);
    reg_chk(0, 6'h01, "R5 status ro");
    toggle(0, 2);
    reg_chk(0, 6'h01, "R5 one detect");
    reg_chk(0, 6'h04, "R6 no det event one pin");
    toggle(0, 3);
    reg_chk(0, 6'h01, "R5 present bits");
    reg_chk(0, 6'h04, "R6 det event");
    toggle(0, 4);
    reg_chk(0, 6'h04, "R6 wprot no event");

    // R7 memory mode then I/O mode
    toggle(1, 0); toggle(1, 1); toggle(1, 5);
    reg_chk(1, 6'h04, "R7 mem mode bits");
    reg_wr(1, 6'h03, 8'h20);
    toggle(1, 0); toggle(1, 1); toggle(1, 5);
    reg_chk(1, 6'h04, "R7 io mode bit0 only");
    reg_wr(1, 6'h03, 8'h00);

    // R9 interrupt enable
    reg_wr(2, 6'h05, 8'h04);
    toggle(2, 1);
    irq_chk("R9 masked event");
    toggle(2, 5);
    irq_chk("R9 enabled event");
    check(irq == 1'b1, "R9 irq high", irq, 1);
    reg_chk(2, 6'h04, "R8 clear on read");
    @(negedge clk);
    irq_chk("R9 irq after clear");

    // R8 event in the same cycle as the change read
    bus_wr(1'b0, 8'h04);
    @(negedge clk); pin_ready[0] = ~pin_ready[0];
    @(negedge clk);
    @(negedge clk); host_sel_data = 1'b1; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
    check(d == 8'h00, "R8 same-cycle read old", d, 0);
    bus_rd(1'b1, d);
    check(d == 8'h04, "R8 same-cycle kept", d, 4);

    // R4 strap decode
    cfg_strap = 2'b01;
    reg_chk(1, 6'h20, "R4 1 socket read zero");
    reg_wr(1, 6'h22, 8'h77);
    reg_wr(1, 6'h05, 8'h0F);
    toggle(1, 0);
    irq_chk("R4 dead socket no irq");
    cfg_strap = 2'b00;
    reg_chk(1, 6'h22, "R4 write ignored");
    reg_chk(1, 6'h04, "R4 no latched event");
    reg_chk(2, 6'h10, "R4 2 sockets read zero");
    cfg_strap = 2'b11;
    reg_chk(2, 6'h10, "R4 4 sockets");

    // random phase
    cfg_strap = 2'b10;
    for (int it = 0; it < 400; it++) begin
      int s, op;
      logic [5:0] r;
      s  = $urandom_range(0, NS-1);
      op = $urandom_range(0, 3);
      r  = 6'($urandom_range(0, 63));
      case (op)
        0: reg_wr(s, r, 8'($urandom()));
        1: reg_chk(s, r, "R3 random read");
        2: toggle(s, $urandom_range(0, 5));
        default: reg_chk(s, 6'h04, "R6 random change");
      endcase
      @(negedge clk);
      irq_chk("R9 random irq");
    end
    summary();
  end
endmodule